// File: doc/BRIEF.md
# Frame Decimation and Field Gate

This block sits on a camera capture path, between the sensor timing decoder and the memory writer. At every frame start it decides whether the frame (or interlaced field) that follows is stored. It then holds that decision for the whole frame and uses it to gate the pixel valid strobe. Two settings drive the decision. The first is a 4-bit decimation code: code 0 keeps every frame, and a code k from 2 to 15 keeps only the first frame of each run of k+1. The second is a 2-bit field select, which limits capture to one field identity or allows both.

Only frames that pass the field filter advance the group counter. The settings are sampled only at a frame start, so the gate never changes inside a frame. When the decimation code changes, or capture is switched off, a fresh group starts, and the next eligible frame is always kept.

Top module: `frame_decim_gate`

## Requirements
- R1: With decimation code 0 and the field filter passing, every frame start sets `frame_accept` to 1 from the next clock edge.
- R2: With decimation code k in 2..15, the eligible frames are counted from the start of a group in groups of k+1. Only frame 0 of each group is accepted (code 2 keeps one in 3; code 15 keeps one in 16).
- R3: Decimation code 1 is reserved and behaves exactly as code 0: every eligible frame is accepted.
- R4: Field select 0 accepts only frames with `field_id`=0. Select 1 accepts only `field_id`=1. Selects 2 and 3 accept either field.
- R5: A frame rejected by the field filter does not advance the decimation group count.
- R6: After reset, `frame_accept` and `pix_valid_out` are 0, and the configuration behaves as code 0 with field select 0.
- R7: `frame_accept` changes only at a clock edge where `frame_start` is 1 and holds until the next frame start. `pix_valid_out` equals `pix_valid_in` AND `frame_accept`.
- R8: A frame start whose decimation code differs from the code seen at the previous frame start begins a new group, and that frame is accepted if it passes the field filter.
- R9: While `cap_en` is 0, frame starts are rejected and the group count is held at 0. The first eligible frame after `cap_en` returns to 1 is accepted.
- R10: Changes to `cfg_decim` or `cfg_field_sel` between two frame starts do not alter `frame_accept` or `pix_valid_out` until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_en | input | 1 | Capture enable; 0 rejects frames and clears the group count |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame or field |
| field_id | input | 1 | Field identity of the frame that is starting |
| pix_valid_in | input | 1 | Pixel valid strobe from the sensor interface |
| cfg_decim | input | 4 | Decimation code (0 or 1: keep all; k: keep 1 of k+1) |
| cfg_field_sel | input | 2 | Field select (0: field 0, 1: field 1, 2/3: either) |
| frame_accept | output | 1 | Current frame is being captured |
| pix_valid_out | output | 1 | Gated pixel valid strobe toward the memory writer |

## Verification
The embedded properties check on every cycle that the accept flag moves only at frame starts, that the group count stays within the range of the active code and clears while capture is off, and that field-0 selection and disabled capture always reject. Other behaviours depend on a sequence of frames, and only the directed scenarios can show them: the exact keep/drop pattern for codes 2 and 15, that filtered frames leave the count alone, that a code change restarts the group, and that a mid-frame configuration write is deferred.

// File: rtl/fdg_pkg.sv
// Package for the frame decimation gate.
// Holds the field-select encoding and the field matching function.
// Assumes a single-bit field identity from the sensor interface.
package fdg_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        FSEL_ONLY_0  = 2'd0,
        FSEL_ONLY_1  = 2'd1,
        FSEL_ANY     = 2'd2,
        FSEL_ANY_ALT = 2'd3
    } fsel_e;

    // True when a frame with the given field identity is eligible under sel.
    function automatic logic field_match(input fsel_e sel, input logic fld);
        case (sel)
            FSEL_ONLY_0: field_match = ~fld;
            FSEL_ONLY_1: field_match = fld;
            default:     field_match = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fdg_field_filter.sv
// Field filter: decides whether the starting frame's field identity
// is eligible for capture under the current field select.
// Purely combinational; the caller samples the result at frame start.
module fdg_field_filter
    import fdg_pkg::*;
(
    input  logic             field_id,
    input  logic [SEL_W-1:0] sel,
    output logic             pass
);

    fsel_e sel_e;

    // Decode the select code and match it against the field identity.
    always_comb begin
        sel_e = fsel_e'(sel);
        pass  = field_match(sel_e, field_id);
    end

endmodule

// File: rtl/fdg_group_counter.sv
// Decimation group counter.
// Counts eligible frames within a group of ratio+1 frames and flags the
// first frame of each group. Codes at or below RSV_CODE mean no decimation.
// Assumes frame_start is a single-cycle pulse; the code is sampled there.
// A change of code at a frame start, or enable low, restarts the group.
module fdg_group_counter #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_start,
    input  logic              field_ok,
    input  logic [CODE_W-1:0] code_in,
    output logic              keep
);

    localparam logic [CODE_W-1:0] RSV_CODE = CODE_W'(1);

    logic [CODE_W-1:0] cnt_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] ratio;
    logic [CODE_W-1:0] cnt_eff;
    logic [CODE_W-1:0] cnt_nxt;
    logic              code_chg;

    // Derive the effective ratio and the count position of this frame.
    always_comb begin
        code_chg = (code_in != code_q);
        ratio    = (code_in <= RSV_CODE) ? '0 : code_in;
        cnt_eff  = code_chg ? '0 : cnt_q;
        keep     = (cnt_eff == '0);
        cnt_nxt  = (cnt_eff >= ratio) ? '0 : cnt_eff + CODE_W'(1);
    end

    // Track the sampled code and advance the count on eligible frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= '0;
        end else if (!enable) begin
            cnt_q  <= '0;
        end else if (frame_start) begin
            code_q <= code_in;
            cnt_q  <= field_ok ? cnt_nxt : cnt_eff;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= code_q) && ((code_q > RSV_CODE) || (cnt_q == '0)));

    // R9
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_q == '0));

endmodule

// File: rtl/frame_decim_gate.sv
// Frame decimation and field gate (top).
// At each frame start, combines capture enable, the field filter and the
// decimation group counter into one accept decision. The decision is
// registered and gates the pixel valid strobe until the next frame start.
// Assumes frame_start is a one-cycle pulse aligned to clk and that pixels
// of a frame arrive after its frame_start cycle.
module frame_decim_gate #(
    parameter int CODE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_en,
    input  logic                      frame_start,
    input  logic                      field_id,
    input  logic                      pix_valid_in,
    input  logic [CODE_W-1:0]         cfg_decim,
    input  logic [fdg_pkg::SEL_W-1:0] cfg_field_sel,
    output logic                      frame_accept,
    output logic                      pix_valid_out
);

    logic field_ok;
    logic keep;
    logic accept_q;

    fdg_field_filter u_filter (
        .field_id (field_id),
        .sel      (cfg_field_sel),
        .pass     (field_ok)
    );

    fdg_group_counter #(
        .CODE_W (CODE_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cap_en),
        .frame_start (frame_start),
        .field_ok    (field_ok),
        .code_in     (cfg_decim),
        .keep        (keep)
    );

    // Latch the accept decision once per frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
        end else if (frame_start) begin
            accept_q <= cap_en & field_ok & keep;
        end
    end

    // Drive the outputs from the latched decision.
    always_comb begin
        frame_accept  = accept_q;
        pix_valid_out = pix_valid_in & accept_q;
    end

    // R7
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_accept));

    // R9
    off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !cap_en) |=> !frame_accept);

    // R4
    field0_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (cfg_field_sel == 2'd0) && field_id) |=> !frame_accept);

    // R1
    pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cap_en && (cfg_decim <= CODE_W'(1)) &&
         (cfg_field_sel[1] || (cfg_field_sel[0] == field_id))) |=> frame_accept);

endmodule

// File: tb/frame_decim_gate_test.sv
// Directed bench for the frame decimation gate: one task per scenario.
module frame_decim_gate_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cap_en;
    logic       frame_start;
    logic       field_id;
    logic       pix_valid_in;
    logic [3:0] cfg_decim;
    logic [1:0] cfg_field_sel;
    logic       frame_accept;
    logic       pix_valid_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    frame_decim_gate uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_en        (cap_en),
        .frame_start   (frame_start),
        .field_id      (field_id),
        .pix_valid_in  (pix_valid_in),
        .cfg_decim     (cfg_decim),
        .cfg_field_sel (cfg_field_sel),
        .frame_accept  (frame_accept),
        .pix_valid_out (pix_valid_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // One frame: pulse frame_start, then stream pixels and check the gate (R7).
    task automatic run_frame(input logic fld, output logic acc);
        @(negedge clk);
        frame_start  = 1'b1;
        field_id     = fld;
        pix_valid_in = 1'b0;
        @(negedge clk);
        frame_start  = 1'b0;
        pix_valid_in = 1'b1;
        #1;
        acc = frame_accept;
        chk("R7 gated valid", int'(pix_valid_out), int'(acc));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk("R7 hold", int'(frame_accept), int'(acc));
        end
        pix_valid_in = 1'b0;
        #1;
        chk("R7 valid low", int'(pix_valid_out), 0);
    endtask

    task automatic expect_frame(input string tag, input logic fld, input logic exp);
        logic acc;
        run_frame(fld, acc);
        chk(tag, int'(acc), int'(exp));
    endtask

    // Start a fresh group by dropping capture enable for one cycle.
    task automatic restart_group();
        @(negedge clk);
        cap_en = 1'b0;
        @(negedge clk);
        cap_en = 1'b1;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        cap_en = 1'b1; frame_start = 1'b0; field_id = 1'b0;
        pix_valid_in = 1'b1; cfg_decim = 4'd0; cfg_field_sel = 2'd0;
        repeat (3) @(negedge clk);
        #1;
        chk("R6 accept at reset", int'(frame_accept), 0);
        chk("R6 valid at reset", int'(pix_valid_out), 0);
        rst_n = 1'b1;
        pix_valid_in = 1'b0;
        expect_frame("R6 default field0", 1'b0, 1'b1);
        expect_frame("R6 default rejects field1", 1'b1, 1'b0);
    endtask

    task automatic test_pass_all();
        cfg_decim = 4'd0; cfg_field_sel = 2'd2;
        for (int i = 0; i < 6; i++) expect_frame("R1 code0 pass", logic'(i % 2), 1'b1);
    endtask

    task automatic test_reserved();
        cfg_decim = 4'd1; cfg_field_sel = 2'd2;
        for (int i = 0; i < 5; i++) expect_frame("R3 code1 pass", 1'b0, 1'b1);
    endtask

    task automatic test_ratio(input int k, input int nframes);
        cfg_field_sel = 2'd2;
        cfg_decim = 4'(k);
        restart_group();
        for (int i = 0; i < nframes; i++)
            expect_frame("R2 decimation", logic'(i % 2), logic'((i % (k + 1)) == 0));
    endtask

    task automatic test_fields();
        cfg_decim = 4'd0;
        for (int s = 0; s < 4; s++) begin
            cfg_field_sel = 2'(s);
            expect_frame("R4 field0", 1'b0, logic'(s != 1));
            expect_frame("R4 field1", 1'b1, logic'(s != 0));
        end
    endtask

    task automatic test_filtered_count();
        cfg_decim = 4'd2; cfg_field_sel = 2'd1;
        restart_group();
        expect_frame("R5 f1 first", 1'b1, 1'b1);
        expect_frame("R5 f0 filtered", 1'b0, 1'b0);
        expect_frame("R5 f1 second", 1'b1, 1'b0);
        expect_frame("R5 f0 filtered", 1'b0, 1'b0);
        expect_frame("R5 f1 third", 1'b1, 1'b0);
        expect_frame("R5 f1 new group", 1'b1, 1'b1);
        expect_frame("R5 f1 second", 1'b1, 1'b0);
    endtask

    task automatic test_code_change();
        cfg_decim = 4'd2; cfg_field_sel = 2'd2;
        restart_group();
        expect_frame("R8 first", 1'b0, 1'b1);
        expect_frame("R8 second", 1'b0, 1'b0);
        cfg_decim = 4'd3;
        expect_frame("R8 restart on change", 1'b0, 1'b1);
        expect_frame("R8 after change", 1'b0, 1'b0);
        expect_frame("R8 after change", 1'b0, 1'b0);
        expect_frame("R8 after change", 1'b0, 1'b0);
        expect_frame("R8 next group", 1'b0, 1'b1);
    endtask

    task automatic test_enable();
        cfg_decim = 4'd3; cfg_field_sel = 2'd2;
        restart_group();
        expect_frame("R9 first", 1'b0, 1'b1);
        expect_frame("R9 second", 1'b0, 1'b0);
        cap_en = 1'b0;
        expect_frame("R9 disabled", 1'b0, 1'b0);
        cap_en = 1'b1;
        expect_frame("R9 first after enable", 1'b0, 1'b1);
        expect_frame("R9 second after enable", 1'b0, 1'b0);
    endtask

    task automatic test_midframe_cfg();
        cfg_decim = 4'd0; cfg_field_sel = 2'd0;
        expect_frame("R10 setup", 1'b0, 1'b1);
        @(negedge clk);
        cfg_field_sel = 2'd1;
        cfg_decim = 4'd5;
        pix_valid_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk("R10 accept kept", int'(frame_accept), 1);
            chk("R10 valid kept", int'(pix_valid_out), 1);
        end
        pix_valid_in = 1'b0;
        expect_frame("R10 new select applied", 1'b0, 1'b0);
        expect_frame("R10 new code group start", 1'b1, 1'b1);
        expect_frame("R10 new code second", 1'b1, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_pass_all();
        test_reserved();
        test_ratio(2, 9);
        test_ratio(15, 34);
        test_fields();
        test_filtered_count();
        test_code_change();
        test_enable();
        test_midframe_cfg();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule